// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a 3-bit synchronous counter that walks a fixed, non-binary loop of five codes, advancing one code per rising clock edge. Its three state bits, named C, B and A, sit in D flip-flops that share one clock. Each next-state bit comes from a small minimized sum-of-products expression.

The three codes outside the loop were don't-cares when those expressions were minimized. The resulting logic still drives each of them into the loop within at most two clocks, so the counter starts itself from any power-up value and recovers from a bit upset. An optional synchronous reset forces the state to all zeros. A combinational flag reports whether the present code belongs to the loop.

Top module: `scnt5_top`

## Requirements
- R1: `state` carries C on bit 2, B on bit 1 and A on bit 0. It is the flip-flop output itself and changes only at a rising clock edge.
- R2: With reset low, a code in the loop advances on each edge along 000 -> 010 -> 011 -> 101 -> 110 and then back to 000 (values written C,B,A).
- R3: The unused code 001 moves to 110 on the next edge.
- R4: The unused code 100 moves to 010 on the next edge.
- R5: The unused code 111 moves to 100 on the next edge and to 010 on the edge after that.
- R6: When `rst` is high at a rising edge, `state` becomes 000 after that edge, whatever the present code.
- R7: `valid` is 1 exactly when `state` is one of 000, 010, 011, 101 or 110. It follows `state` with no register in between.
- R8: From any of the eight codes, `valid` is 1 no later than two edges after reset is released. From then on the counter stays in the loop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 000 |
| state | output | 3 | Present code {C,B,A} |
| valid | output | 1 | High while the present code is in the five-code loop |

## Verification
Each code change is due one edge after the state that causes it. Recovery from 111 takes two edges, and reset takes effect one edge after it is sampled. The bench samples every result on the falling edge that follows the rising edge that produced it. A queue holds one expected code per falling edge, and a driver fills it only after the previous stimulus has drained. Each start code is injected while reset is held high. The first compared value is therefore the code one edge after release, and the two-edge recovery bound is checked on the second falling edge after release.

// File: rtl/scnt5_pkg.sv
package scnt5_pkg;

    localparam int STATE_W = 3;
    localparam logic [STATE_W-1:0] RESET_CODE = 3'b000;

    typedef struct packed {
        logic c;
        logic b;
        logic a;
    } scnt_state_t;

    // Minimized next-state equations; unused codes were don't-cares.
    function automatic scnt_state_t scnt_next(input scnt_state_t s);
        scnt_state_t n;
        n.c = s.a;
        n.b = ~s.b | (~s.a & ~s.c);
        n.a = s.b & ~s.c;
        return n;
    endfunction

    // In the loop unless the code is one of the three unused ones.
    function automatic logic scnt_in_loop(input scnt_state_t s);
        logic bad;
        bad = (~s.c & ~s.b &  s.a)
            | ( s.c & ~s.b & ~s.a)
            | ( s.c &  s.b &  s.a);
        return ~bad;
    endfunction

endpackage

// File: rtl/scnt5_next.sv
module scnt5_next
    import scnt5_pkg::*;
(
    input  scnt_state_t cur,
    output scnt_state_t nxt
);
    always_comb begin
        nxt = scnt_next(cur);
    end
endmodule

// File: rtl/scnt5_reg.sv
module scnt5_reg
    import scnt5_pkg::*;
#(
    parameter bit HAS_RST = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] d,
    output logic [STATE_W-1:0] q
);
    generate
        if (HAS_RST) begin : g_rst
            always_ff @(posedge clk) begin
                if (rst) q <= RESET_CODE;
                else     q <= d;
            end
        end else begin : g_free
            logic unused_rst;
            assign unused_rst = rst;
            always_ff @(posedge clk) begin
                q <= d;
            end
        end
    endgenerate
endmodule

// File: rtl/scnt5_decode.sv
module scnt5_decode
    import scnt5_pkg::*;
(
    input  scnt_state_t cur,
    output logic        in_loop
);
    always_comb begin
        in_loop = scnt_in_loop(cur);
    end
endmodule

// File: rtl/scnt5_top.sv
module scnt5_top
    import scnt5_pkg::*;
#(
    parameter bit HAS_RST = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    output logic [STATE_W-1:0] state,
    output logic               valid
);
    scnt_state_t       cur_s;
    scnt_state_t       nxt_s;
    logic [STATE_W-1:0] q_bits;

    assign cur_s = scnt_state_t'(q_bits);

    scnt5_next u_next (
        .cur (cur_s),
        .nxt (nxt_s)
    );

    scnt5_reg #(.HAS_RST(HAS_RST)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (nxt_s),
        .q   (q_bits)
    );

    scnt5_decode u_dec (
        .cur     (cur_s),
        .in_loop (valid)
    );

    assign state = q_bits;
endmodule

// File: rtl/scnt5_chk.sv
module scnt5_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] state,
    input logic       valid
);
    function automatic logic [2:0] loop_succ(input logic [2:0] s);
        case (s)
            3'b000:  return 3'b010;
            3'b010:  return 3'b011;
            3'b011:  return 3'b101;
            3'b101:  return 3'b110;
            default: return 3'b000;
        endcase
    endfunction

    // R2: a loop code steps to its successor
    a_r2_loop_step: assert property (@(posedge clk) disable iff (rst)
        valid |=> (state == loop_succ($past(state))));

    a_r3_from_001: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b001) |=> (state == 3'b110));

    a_r4_from_100: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b100) |=> (state == 3'b010));

    a_r5_from_111: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b111) |=> (state == 3'b100));

    // R8: once in the loop, it stays there
    a_r8_closure: assert property (@(posedge clk) disable iff (rst)
        valid |=> valid);

    // R7: the flag is 0 on every unused code
    a_r7_flag_unused: assert property (@(posedge clk) disable iff (rst)
        (state inside {3'b001, 3'b100, 3'b111}) |-> !valid);
endmodule

bind scnt5_top scnt5_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .state (state),
    .valid (valid)
);

// File: tb/test_scnt5_top.sv
module test_scnt5_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] state;
    logic       valid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [2:0] code;
        string      req;
    } exp_t;
    exp_t expq[$];

    always #2 clk = ~clk;

    scnt5_top i_scnt5_top (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .valid (valid)
    );

    function automatic logic [2:0] model_next(input logic [2:0] s);
        case (s)
            3'b000:  return 3'b010;
            3'b010:  return 3'b011;
            3'b011:  return 3'b101;
            3'b101:  return 3'b110;
            3'b110:  return 3'b000;
            3'b001:  return 3'b110;
            3'b100:  return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic logic model_valid(input logic [2:0] s);
        return (s == 3'b000) || (s == 3'b010) || (s == 3'b011) ||
               (s == 3'b101) || (s == 3'b110);
    endfunction

    function automatic string step_req(input logic [2:0] s);
        case (s)
            3'b001:  return "R3";
            3'b100:  return "R4";
            3'b111:  return "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: one expected item per falling edge
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            check(state == e.code, e.req, "state", int'(state), int'(e.code));
            check(valid == model_valid(e.code), "R7", "valid",
                  int'(valid), int'(model_valid(e.code)));
        end
    end

    task automatic push_run(input logic [2:0] from, input int steps);
        logic [2:0] s;
        s = from;
        for (int i = 0; i < steps; i++) begin
            exp_t e;
            e.req  = step_req(s);
            s      = model_next(s);
            e.code = s;
            expq.push_back(e);
        end
    endtask

    task automatic start_from(input logic [2:0] code, input int steps);
        wait (expq.size() == 0);
        @(negedge clk);
        rst = 1'b1;
        force i_scnt5_top.u_reg.q = code;
        @(negedge clk);
        release i_scnt5_top.u_reg.q;
        rst = 1'b0;
        #1;
        push_run(code, steps);
        // R8: in the loop by the second falling edge after release
        repeat (2) @(negedge clk);
        #1;
        check(valid == 1'b1, "R8", "valid two edges after start", int'(valid), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R6: reset state
        repeat (3) @(negedge clk);
        check(state == 3'b000, "R6", "state in reset", int'(state), 0);
        check(valid == 1'b1, "R7", "valid in reset", int'(valid), 1);
        rst = 1'b0;
        #1;
        push_run(3'b000, 15);
        wait (expq.size() == 0);

        // R1: no change between edges
        for (int i = 0; i < 4; i++) begin
            logic [2:0] s0;
            @(negedge clk);
            #0.5;
            s0 = state;
            #1;
            check(state == s0, "R1", "state stable between edges", int'(state), int'(s0));
        end

        // R6: reset in mid-run has priority over the next code
        @(negedge clk);
        rst = 1'b1;
        #1;
        begin
            exp_t e;
            e.code = 3'b000;
            e.req  = "R6";
            expq.push_back(e);
        end
        @(negedge clk);
        rst = 1'b0;
        #1;
        push_run(3'b000, 6);

        // every start code, then three full loops
        for (int c = 0; c < 8; c++) begin
            start_from(3'(c), 17);
        end
        wait (expq.size() == 0);
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule